// File: doc/BRIEF.md
# Sync separator with coast window

This block recovers vertical sync from an active-low composite sync stream. It integrates the sync level over ticks of a slow sampling clock (a clock enable, nominally near 5 MHz). An up/down duration counter rises on every tick that sees sync low and falls on every tick that sees it high. Horizontal sync and equalization pulses are shorter than the programmed threshold, so they never lift the counter far enough. Only the long serrated vertical interval does.

The block also drives a coast signal that tells a downstream line-lock loop to hold its phase while vertical sync disturbs the line timing. It counts pixel-domain horizontal sync edges since the last vertical sync start and keeps the total of the previous frame. From that total it predicts where the next vertical sync will begin. Coast can open a programmable number of lines before that point, always covers vertical sync itself, and can stay on for a programmable number of lines afterwards. A presence flag reports whether vertical sync is arriving at all.

A threshold setting of 0x20 suits standard line rates when the sample clock runs near 5 MHz. Pre-coast and post-coast settings of 0 give a coast that spans only the vertical sync interval.

The integrator has two named states:
- SEP_WAIT goes to SEP_VSYNC on a tick that brings the count to the threshold ("capture").
- SEP_VSYNC goes back to SEP_WAIT on a tick that brings the count to 0 ("release").

The coast machine has four named states: CST_IDLE, CST_PRE, CST_VSYNC and CST_POST. Its transitions are:
- "enter" goes from any state to CST_VSYNC while vertical sync is high.
- "predict" goes from CST_IDLE to CST_PRE when the predicted window line has been reached.
- "drop" goes from CST_PRE to CST_IDLE when the prediction becomes invalid.
- "trail" goes from CST_VSYNC to CST_POST when vertical sync ends and the post count is non-zero.
- "finish" goes from CST_VSYNC or CST_POST to CST_IDLE, or to CST_PRE if the window is already due, when vertical sync ends with a post count of 0 or when the post count has been reached.

Top module: `sync_sep_coast`

## Requirements
- R1: While reset is applied and on the first cycle after it, vsync_o, coast_o and vs_present_o are all 0.
- R2: On a clock where tick_en is 1, the 8-bit duration count goes up by one if csync_n is 0 and down by one if csync_n is 1. It holds at 255 and at 0 rather than wrapping. On a clock where tick_en is 0 the count does not change, whatever level csync_n has.
- R3: vsync_o becomes 1 at the clock edge of the tick that brings the count to cfg_thresh; a threshold of 0 behaves as 1. A run of low ticks shorter than the threshold, followed by an equal run of high ticks, never sets vsync_o.
- R4: vsync_o returns to 0 at the clock edge of the tick that brings the count back to 0. Leaving vertical sync therefore takes as many high ticks as the count had accumulated.
- R5: coast_o becomes 1 one clock after vsync_o becomes 1. With cfg_post of 0 and no pending pre-window, coast_o becomes 0 one clock after vsync_o becomes 0.
- R6: With cfg_post = P, where P is not 0, coast_o stays 1 after vsync_o falls. It becomes 0 at the clock edge that samples the P-th falling edge of hsync_n counted after vertical sync ends.
- R7: The line count is the number of hsync_n falling edges since the last vertical sync start; it is 0 at that start. With cfg_pre not 0 and a valid prediction, coast_o becomes 1 one clock after the line count reaches (previous frame line count − cfg_pre), and it stays 1 into vertical sync.
- R8: When cfg_pre exceeds the previous frame line count, the window line is 0. Coast then passes straight from the vertical sync interval (or the post window) into the pre-window, with no clock of coast_o at 0.
- R9: vs_present_o becomes 1 one clock after vsync_o rises. It becomes 0 at the edge that counts the 4096th hsync_n falling edge since the last vertical sync start. A prediction is formed only from a frame whose starting vertical sync arrived while vs_present_o was already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-clock enable marking each slow sample tick |
| csync_n | input | 1 | Composite sync, active low |
| hsync_n | input | 1 | Pixel-domain horizontal sync, active low |
| cfg_thresh | input | 8 | Tick count that must accumulate before vertical sync is declared |
| cfg_pre | input | 8 | Lines of coast opened before the predicted vertical sync |
| cfg_post | input | 8 | Lines of coast kept after vertical sync ends |
| vsync_o | output | 1 | Extracted vertical sync, active high |
| coast_o | output | 1 | Hold request for the downstream line-lock loop |
| vs_present_o | output | 1 | Vertical sync has been seen recently |

## Verification
Every result has a fixed latency:
- vsync_o is registered at the very edge that samples the deciding tick.
- coast_o follows one edge later, because the coast machine reads the registered vertical sync and the registered line count.
- The post window closes at the edge that samples the hsync_n fall.

The bench changes inputs on falling clock edges. Its tick task returns one falling edge after the sampling edge, so vsync_o is read there. For coast_o it waits one more clock after a vertical sync change. Its line task holds each line for four clocks before returning, which leaves room for the one-clock window delay before coast_o is read.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    // Duration integrator states
    typedef enum logic {
        SEP_WAIT  = 1'b0,
        SEP_VSYNC = 1'b1
    } sep_state_e;

    // Coast window states
    typedef enum logic [1:0] {
        CST_IDLE  = 2'd0,
        CST_PRE   = 2'd1,
        CST_VSYNC = 2'd2,
        CST_POST  = 2'd3
    } cst_state_e;

endpackage

// File: rtl/ssc_integrator.sv
module ssc_integrator
    import ssc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             csync_n,
    input  logic [CNT_W-1:0] thresh,
    output logic             vsync_o,
    output logic             vs_start_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    sep_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] thr_eff;
    logic             vs_prev_q;

    // Up/down duration count, saturating at both ends
    always_comb begin
        cnt_d = cnt_q;
        if (tick_en) begin
            if (!csync_n) begin
                if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
            end else begin
                if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            end
        end
    end

    assign thr_eff = (thresh == '0) ? CNT_ONE : thresh;

    // Next state: capture / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEP_WAIT:  if (tick_en && (cnt_d >= thr_eff)) state_d = SEP_VSYNC;
            SEP_VSYNC: if (tick_en && (cnt_d == '0))      state_d = SEP_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEP_WAIT;
            cnt_q     <= '0;
            vs_prev_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            vs_prev_q <= vsync_o;
        end
    end

    // Outputs
    always_comb begin
        vsync_o    = (state_q == SEP_VSYNC);
        vs_start_o = vsync_o && !vs_prev_q;
    end

    assert_sat_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !csync_n && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_o) |-> (cnt_q >= $past(thresh) && cnt_q != '0));

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_o) |-> (cnt_q == '0));

endmodule

// File: rtl/ssc_line_tracker.sv
module ssc_line_tracker #(
    parameter int CFG_W      = 8,
    parameter int LOSS_LINES = 4096,
    parameter int LINE_W     = $clog2(LOSS_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_n,
    input  logic              vs_start,
    input  logic [CFG_W-1:0]  pre_lines,
    output logic              line_evt_o,
    output logic [LINE_W-1:0] line_cnt_o,
    output logic [LINE_W-1:0] coast_line_o,
    output logic              pred_valid_o,
    output logic              present_o
);

    localparam logic [LINE_W-1:0] LOSS_L = LINE_W'(LOSS_LINES);

    logic              hs_q;
    logic [LINE_W-1:0] line_cnt_q;
    logic [LINE_W-1:0] prev_q;
    logic              present_q;
    logic              pred_q;
    logic [LINE_W-1:0] pre_ext;

    // Falling edge of horizontal sync marks a new line
    assign line_evt_o = hs_q && !hsync_n;
    assign pre_ext    = LINE_W'(pre_lines);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q       <= 1'b1;
            line_cnt_q <= '0;
            prev_q     <= '0;
            present_q  <= 1'b0;
            pred_q     <= 1'b0;
        end else begin
            hs_q <= hsync_n;
            if (vs_start) begin
                line_cnt_q <= '0;
                prev_q     <= line_cnt_q;
                present_q  <= 1'b1;
                pred_q     <= present_q;
            end else if (line_evt_o) begin
                if (line_cnt_q != LOSS_L) line_cnt_q <= line_cnt_q + 1'b1;
                if (line_cnt_q == LOSS_L - 1'b1) begin
                    present_q <= 1'b0;
                    pred_q    <= 1'b0;
                end
            end
        end
    end

    // Predicted window line, clamped at line 0
    assign coast_line_o = (pre_ext > prev_q) ? '0 : (prev_q - pre_ext);
    assign line_cnt_o   = line_cnt_q;
    assign pred_valid_o = pred_q;
    assign present_o    = present_q;

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vs_start |=> (line_cnt_q == '0 && present_q));

    assert_pred_needs_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !present_q |-> !pred_q);

    assert_line_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt_q <= LOSS_L);

endmodule

// File: rtl/ssc_coast_fsm.sv
module ssc_coast_fsm
    import ssc_pkg::*;
#(
    parameter int CFG_W  = 8,
    parameter int LINE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              line_evt_i,
    input  logic [LINE_W-1:0] line_cnt_i,
    input  logic [LINE_W-1:0] coast_line_i,
    input  logic              pred_valid_i,
    input  logic [CFG_W-1:0]  pre_lines_i,
    input  logic [CFG_W-1:0]  post_lines_i,
    output logic              coast_o
);

    cst_state_e       state_q, state_d;
    logic [CFG_W-1:0] post_cnt_q;
    logic [CFG_W:0]   post_next;
    logic             pre_hit;
    logic             post_done;
    cst_state_e       rest_state;

    assign pre_hit    = pred_valid_i && (pre_lines_i != '0) && (line_cnt_i >= coast_line_i);
    assign post_next  = {1'b0, post_cnt_q} + 1'b1;
    assign post_done  = line_evt_i && (post_next >= {1'b0, post_lines_i});
    assign rest_state = pre_hit ? CST_PRE : CST_IDLE;

    // Next state: enter / predict / drop / trail / finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CST_IDLE: begin
                if (vsync_i)      state_d = CST_VSYNC;
                else if (pre_hit) state_d = CST_PRE;
            end
            CST_PRE: begin
                if (vsync_i)            state_d = CST_VSYNC;
                else if (!pred_valid_i) state_d = CST_IDLE;
            end
            CST_VSYNC: begin
                if (!vsync_i) state_d = (post_lines_i != '0) ? CST_POST : rest_state;
            end
            CST_POST: begin
                if (vsync_i)        state_d = CST_VSYNC;
                else if (post_done) state_d = rest_state;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= CST_IDLE;
            post_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != CST_POST)  post_cnt_q <= '0;
            else if (line_evt_i)      post_cnt_q <= post_cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        coast_o = (state_q != CST_IDLE);
    end

    assert_follow_vsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_i |=> coast_o);

    assert_release_after_vsync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coast_o) |-> !$past(vsync_i));

    assert_window_needs_pred_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(coast_o) && !$past(vsync_i)) |-> $past(pred_valid_i));

endmodule

// File: rtl/sync_sep_coast.sv
module sync_sep_coast #(
    parameter int CNT_W      = 8,
    parameter int CFG_W      = 8,
    parameter int LOSS_LINES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             csync_n,
    input  logic             hsync_n,
    input  logic [CNT_W-1:0] cfg_thresh,
    input  logic [CFG_W-1:0] cfg_pre,
    input  logic [CFG_W-1:0] cfg_post,
    output logic             vsync_o,
    output logic             coast_o,
    output logic             vs_present_o
);

    localparam int LINE_W = $clog2(LOSS_LINES + 1);

    logic              vs_start;
    logic              line_evt;
    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] coast_line;
    logic              pred_valid;

    ssc_integrator #(
        .CNT_W (CNT_W)
    ) u_integrator (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .csync_n    (csync_n),
        .thresh     (cfg_thresh),
        .vsync_o    (vsync_o),
        .vs_start_o (vs_start)
    );

    ssc_line_tracker #(
        .CFG_W      (CFG_W),
        .LOSS_LINES (LOSS_LINES),
        .LINE_W     (LINE_W)
    ) u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .hsync_n      (hsync_n),
        .vs_start     (vs_start),
        .pre_lines    (cfg_pre),
        .line_evt_o   (line_evt),
        .line_cnt_o   (line_cnt),
        .coast_line_o (coast_line),
        .pred_valid_o (pred_valid),
        .present_o    (vs_present_o)
    );

    ssc_coast_fsm #(
        .CFG_W  (CFG_W),
        .LINE_W (LINE_W)
    ) u_coast (
        .clk          (clk),
        .rst_n        (rst_n),
        .vsync_i      (vsync_o),
        .line_evt_i   (line_evt),
        .line_cnt_i   (line_cnt),
        .coast_line_i (coast_line),
        .pred_valid_i (pred_valid),
        .pre_lines_i  (cfg_pre),
        .post_lines_i (cfg_post),
        .coast_o      (coast_o)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!vsync_o && !coast_o && !vs_present_o));

endmodule

// File: tb/test_sync_sep_coast.sv
module test_sync_sep_coast;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       csync_n = 1'b1;
    logic       hsync_n = 1'b1;
    logic [7:0] thr = 8'h20;
    logic [7:0] pre = 8'd0;
    logic [7:0] post = 8'd0;
    logic       vsync_o, coast_o, vs_present_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sync_sep_coast i_sync_sep_coast (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .csync_n      (csync_n),
        .hsync_n      (hsync_n),
        .cfg_thresh   (thr),
        .cfg_pre      (pre),
        .cfg_post     (post),
        .vsync_o      (vsync_o),
        .coast_o      (coast_o),
        .vs_present_o (vs_present_o)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; csync_n = 1'b1; hsync_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One slow-clock tick at the given sync level; returns one clock after sampling
    task automatic tick(input logic lvl);
        @(negedge clk);
        csync_n = lvl; tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    // One line: hsync_n low one clock, then high three clocks
    task automatic line();
        @(negedge clk);
        hsync_n = 1'b0;
        @(negedge clk);
        hsync_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic vs_frame();
        for (int i = 0; i < int'(thr); i++) tick(1'b0);
        for (int i = 0; i < int'(thr); i++) tick(1'b1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(vsync_o, 1'b0, "R1 vsync in reset");
        chk(coast_o, 1'b0, "R1 coast in reset");
        chk(vs_present_o, 1'b0, "R1 present in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(vsync_o | coast_o | vs_present_o, 1'b0, "R1 outputs after reset");
    endtask

    task automatic t_threshold();
        thr = 8'd4; do_reset();
        for (int i = 0; i < 3; i++) tick(1'b0);
        chk(vsync_o, 1'b0, "R3 below threshold");
        tick(1'b0);
        chk(vsync_o, 1'b1, "R3 at threshold");
        for (int i = 0; i < 3; i++) tick(1'b1);
        chk(vsync_o, 1'b1, "R4 count not yet zero");
        tick(1'b1);
        chk(vsync_o, 1'b0, "R4 count back to zero");
    endtask

    task automatic t_reject();
        thr = 8'd4; do_reset();
        for (int p = 0; p < 5; p++) begin
            for (int i = 0; i < 3; i++) tick(1'b0);
            for (int i = 0; i < 3; i++) tick(1'b1);
            chk(vsync_o, 1'b0, "R3 short pulse rejected");
        end
    endtask

    task automatic t_updown();
        thr = 8'd4; do_reset();
        for (int i = 0; i < 6; i++) tick(1'b0);
        chk(vsync_o, 1'b1, "R2 counted up");
        for (int i = 0; i < 5; i++) tick(1'b1);
        chk(vsync_o, 1'b1, "R2 counted down partly");
        tick(1'b1);
        chk(vsync_o, 1'b0, "R4 release after matching high ticks");
    endtask

    task automatic t_saturate();
        thr = 8'd255; do_reset();
        for (int i = 0; i < 300; i++) tick(1'b0);
        chk(vsync_o, 1'b1, "R2 long low reaches 255");
        for (int i = 0; i < 254; i++) tick(1'b1);
        chk(vsync_o, 1'b1, "R2 top saturation 254 down");
        tick(1'b1);
        chk(vsync_o, 1'b0, "R2 top saturation 255 down");
        for (int i = 0; i < 10; i++) tick(1'b1);
        thr = 8'd4;
        for (int i = 0; i < 3; i++) tick(1'b0);
        chk(vsync_o, 1'b0, "R2 floor saturation no wrap");
        tick(1'b0);
        chk(vsync_o, 1'b1, "R2 floor saturation reaches 4");
        for (int i = 0; i < 4; i++) tick(1'b1);
    endtask

    task automatic t_no_tick();
        thr = 8'd1; do_reset();
        @(negedge clk);
        csync_n = 1'b0;
        repeat (20) @(negedge clk);
        chk(vsync_o, 1'b0, "R2 no tick no count");
        csync_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_thr_zero();
        thr = 8'd0; do_reset();
        tick(1'b0);
        chk(vsync_o, 1'b1, "R3 threshold 0 acts as 1");
        tick(1'b1);
        chk(vsync_o, 1'b0, "R4 threshold 0 release");
    endtask

    task automatic t_coast_basic();
        thr = 8'd4; pre = 8'd0; post = 8'd0; do_reset();
        for (int i = 0; i < 4; i++) tick(1'b0);
        chk(coast_o, 1'b0, "R5 coast lags vsync");
        chk(vs_present_o, 1'b0, "R9 present lags vsync");
        @(negedge clk);
        chk(coast_o, 1'b1, "R5 coast one clock after vsync");
        chk(vs_present_o, 1'b1, "R9 present set");
        for (int i = 0; i < 4; i++) tick(1'b1);
        chk(coast_o, 1'b1, "R5 coast held at vsync fall");
        @(negedge clk);
        chk(coast_o, 1'b0, "R5 coast drops one clock after vsync");
    endtask

    task automatic t_post();
        thr = 8'd4; pre = 8'd0; post = 8'd2; do_reset();
        vs_frame();
        chk(coast_o, 1'b1, "R6 post window open");
        line();
        chk(coast_o, 1'b1, "R6 after first post line");
        line();
        chk(coast_o, 1'b0, "R6 closed after second post line");
    endtask

    task automatic t_pre();
        thr = 8'd4; pre = 8'd3; post = 8'd0; do_reset();
        for (int i = 0; i < 10; i++) line();
        vs_frame();
        for (int i = 1; i <= 10; i++) begin
            line();
            chk(coast_o, 1'b0, "R9 no prediction from partial frame");
        end
        vs_frame();
        for (int i = 1; i <= 10; i++) begin
            line();
            chk(coast_o, (i >= 7) ? 1'b1 : 1'b0, "R7 window opens at line 7");
        end
        vs_frame();
        chk(coast_o, 1'b0, "R7 window closed after vsync");
    endtask

    task automatic t_pre_clamp();
        thr = 8'd4; pre = 8'd20; post = 8'd0; do_reset();
        vs_frame();
        for (int i = 0; i < 10; i++) line();
        for (int i = 0; i < 4; i++) tick(1'b0);
        for (int i = 0; i < 4; i++) begin
            tick(1'b1);
            chk(coast_o, 1'b1, "R8 coast through vsync");
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(coast_o, 1'b1, "R8 no gap after vsync");
        end
        line();
        chk(coast_o, 1'b1, "R8 window from line 0");
    endtask

    task automatic t_loss();
        thr = 8'd4; pre = 8'd0; post = 8'd0; do_reset();
        vs_frame();
        chk(vs_present_o, 1'b1, "R9 present after vsync");
        for (int i = 0; i < 4095; i++) line();
        chk(vs_present_o, 1'b1, "R9 present at 4095 lines");
        line();
        chk(vs_present_o, 1'b0, "R9 lost at 4096 lines");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_threshold();
        t_reject();
        t_updown();
        t_saturate();
        t_no_tick();
        t_thr_zero();
        t_coast_basic();
        t_post();
        t_pre();
        t_pre_clamp();
        t_loss();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule